// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between the receive deserializer of a UART and its register read interface. Every character that arrives is stored as a 12-bit entry: the data byte plus four status flags covering framing error, parity error, break and overrun. The deserializer itself is not part of the block. It is replaced by a one-cycle `char_valid` strobe that carries the byte and its three line-error flags.

Two storage modes are provided. In queue mode the entries go into a first-in first-out store of `DEPTH` entries, 16 by default. In single mode, storage shrinks to one holding register. The read side has three parts:
- a data-read strobe, which returns the oldest entry on `rd_word`;
- a separate status register, `rx_status`;
- an error-clear strobe.

The three line-error bits of the status register change only when a data read takes place. The overrun bit is set as soon as an overrun happens. For this reason software must read the data before it reads the status.

`rx_empty` and `rx_full` describe whichever storage is active. Changing the mode discards everything that is stored.

Top module: `rx_char_buffer`

## Requirements
- R1: Each entry has this layout: data byte in bits 7:0, framing error in bit 8, parity error in bit 9, break in bit 10, overrun in bit 11. A data read presents the oldest entry on `rd_word` in the cycle after the read strobe.
- R2: With `fifo_mode`=1, up to DEPTH (16) characters are stored and read back in arrival order. `rx_full` is 1 exactly when DEPTH entries are held.
- R3: With `fifo_mode`=0, storage is one holding register, so `rx_full` rises after a single character.
- R4: `rx_status` bits 2:0 (framing, parity, break) are loaded from bits 10:8 of the entry being read, and only on a successful data read. An arriving character leaves them unchanged.
- R5: A character that arrives while storage is full, with no read in the same cycle, is discarded. In the cycle after it arrives, `rx_status` bit 3 reads 1 without any read. Bit 11 is set in the most recently stored entry.
- R6: A pulse on `clr_err` makes `rx_status` read 0 in the next cycle. The clear takes priority over an overrun in the same cycle.
- R7: After reset, `rx_status`=0, `rd_word`=0, `rx_empty`=1 and `rx_full`=0.
- R8: A data read while storage is empty leaves `rd_word`, `rx_status` and the flags unchanged.
- R9: A change of `fifo_mode` empties the storage. A character that arrives in the cycle where the change is seen is dropped without an overrun.
- R10: When storage is full, a read and an arrival in the same cycle both take effect, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = queue of DEPTH entries, 0 = single holding register |
| char_valid | input | 1 | One-cycle strobe: a character was received |
| char_data | input | 8 | Received data byte |
| char_ferr | input | 1 | Framing error of the received character |
| char_perr | input | 1 | Parity error of the received character |
| char_brk | input | 1 | Break detected on the received character |
| rd_data | input | 1 | Data-register read strobe |
| clr_err | input | 1 | Error-clear write strobe |
| rd_word | output | 12 | Entry returned by the last successful data read |
| rx_status | output | 4 | Status: bit0 framing, bit1 parity, bit2 break, bit3 overrun |
| rx_empty | output | 1 | Active storage holds no entry |
| rx_full | output | 1 | Active storage has no free entry |

## Verification
The hardest case to reach is an overrun whose flag has to land on the right stored entry while the status reports it before any read. The stimulus fills all sixteen queue slots, then sends one more character. It checks status bit 3 at once, then drains the queue and expects bit 11 only on the last word. The same full state is then rebuilt to hit the same-cycle read-and-arrival case. The mode is also switched with entries still stored, and with a character arriving in the switch cycle, to show that the flush discards both.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ENTRY_W = BYTE_W + 4;

  typedef struct packed {
    logic              ovr;   // bit 11
    logic              brk;   // bit 10
    logic              perr;  // bit 9
    logic              ferr;  // bit 8
    logic [BYTE_W-1:0] data;  // bits 7:0
  } rx_entry_t;
endpackage

// File: rtl/rx_buf_store.sv
module rx_buf_store
  import rx_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_one,
  input  logic      flush,
  input  logic      push,
  input  logic      pop,
  input  logic      mark_ovr,
  input  rx_entry_t wr_entry,
  output rx_entry_t head,
  output logic      empty,
  output logic      full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d, newest;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cap;

  assign cap    = cap_one ? CW'(1) : CAP_Q;
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == cap);
  assign head   = mem[rptr_q];
  assign newest = (wptr_q == '0) ? LAST : wptr_q - AW'(1);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
      if (pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
      if (push && !pop)      cnt_d = cnt_q + CW'(1);
      else if (pop && !push) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush)          mem[wptr_q]     <= wr_entry;
    else if (mark_ovr && !flush) mem[newest].ovr <= 1'b1;
  end
endmodule

// File: rtl/rx_buf_status.sv
module rx_buf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [2:0] line_flags,
  input  logic       ovr_evt,
  output logic [3:0] stat
);
  logic [3:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr) begin
      stat_d = '0;
    end else begin
      if (load)    stat_d[2:0] = line_flags;
      if (ovr_evt) stat_d[3]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rx_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_mode,
  input  logic               char_valid,
  input  logic [BYTE_W-1:0]  char_data,
  input  logic               char_ferr,
  input  logic               char_perr,
  input  logic               char_brk,
  input  logic               rd_data,
  input  logic               clr_err,
  output logic [ENTRY_W-1:0] rd_word,
  output logic [3:0]         rx_status,
  output logic               rx_empty,
  output logic               rx_full
);
  logic      mode_q, flush;
  logic      rd_ok, push, ovr_evt;
  rx_entry_t in_entry, head;
  logic [ENTRY_W-1:0] word_q, word_d;

  assign flush   = fifo_mode ^ mode_q;
  assign rd_ok   = rd_data && !rx_empty && !flush;
  assign push    = char_valid && !flush && (!rx_full || rd_ok);
  assign ovr_evt = char_valid && !flush && rx_full && !rd_ok;

  assign in_entry = '{ovr: 1'b0, brk: char_brk, perr: char_perr,
                      ferr: char_ferr, data: char_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  rx_buf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_one  (!mode_q),
    .flush    (flush),
    .push     (push),
    .pop      (rd_ok),
    .mark_ovr (ovr_evt),
    .wr_entry (in_entry),
    .head     (head),
    .empty    (rx_empty),
    .full     (rx_full)
  );

  rx_buf_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_err),
    .load       (rd_ok),
    .line_flags ({head.brk, head.perr, head.ferr}),
    .ovr_evt    (ovr_evt),
    .stat       (rx_status)
  );

  always_comb begin
    word_d = word_q;
    if (rd_ok) word_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign rd_word = word_q;
endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_mode,
  input logic        char_valid,
  input logic        rd_data,
  input logic        clr_err,
  input logic [11:0] rd_word,
  input logic [3:0]  rx_status,
  input logic        rx_empty,
  input logic        rx_full
);
  logic mode_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_seen <= 1'b0;
    else        mode_seen <= fifo_mode;
  end

  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  // R5
  ovr_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && rx_full && !rd_data && !clr_err && (fifo_mode == mode_seen)
    |=> rx_status[3]);

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (rx_status == 4'h0));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data && !clr_err |=> $stable(rx_status[2:0]));

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data |=> $stable(rd_word));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && rx_empty && !clr_err |=> $stable(rd_word) && $stable(rx_status[2:0]));

  // R3
  store_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && rx_empty && !rd_data && (fifo_mode == mode_seen) |=> !rx_empty);
endmodule

bind rx_char_buffer rx_char_buffer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_mode  (fifo_mode),
  .char_valid (char_valid),
  .rd_data    (rd_data),
  .clr_err    (clr_err),
  .rd_word    (rd_word),
  .rx_status  (rx_status),
  .rx_empty   (rx_empty),
  .rx_full    (rx_full)
);

// File: tb/rx_char_buffer_bench.sv
`timescale 1ns/1ps
module rx_char_buffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b1, char_valid = 1'b0, rd_data = 1'b0, clr_err = 1'b0;
  logic [7:0] char_data = '0;
  logic char_ferr = 1'b0, char_perr = 1'b0, char_brk = 1'b0;
  logic [11:0] rd_word;
  logic [3:0]  rx_status;
  logic        rx_empty, rx_full;

  int total = 0, bad = 0, cap = 16;
  bit done = 0;
  logic [11:0] exp_q[$];
  logic [11:0] last_w = '0;
  logic [3:0]  mstat = '0;

  always #4 clk = ~clk;

  rx_char_buffer u_rx_char_buffer (.*);

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " empty"}, {11'd0, rx_empty}, {11'd0, exp_q.size() == 0});
    chk({tag, " full"},  {11'd0, rx_full},  {11'd0, exp_q.size() == cap});
  endtask

  // driver: one character, expected entry goes into the scoreboard
  task automatic send(input logic [7:0] d, input logic f, input logic p, input logic b);
    char_valid = 1; char_data = d; char_ferr = f; char_perr = p; char_brk = b;
    @(negedge clk);
    char_valid = 0;
    if (exp_q.size() < cap) exp_q.push_back({1'b0, b, p, f, d});
    else begin
      exp_q[exp_q.size()-1][11] = 1'b1;
      mstat[3] = 1'b1;
    end
  endtask

  // monitor: data read compared against scoreboard head
  task automatic read(input string tag);
    rd_data = 1;
    @(negedge clk);
    rd_data = 0;
    if (exp_q.size() > 0) begin
      last_w = exp_q.pop_front();
      mstat[2:0] = last_w[10:8];
    end
    chk({tag, " word"}, rd_word, last_w);
    chk({tag, " status"}, {8'd0, rx_status}, {8'd0, mstat});
  endtask

  task automatic read_and_send(input logic [7:0] d);
    rd_data = 1; char_valid = 1; char_data = d;
    char_ferr = 0; char_perr = 0; char_brk = 0;
    @(negedge clk);
    rd_data = 0; char_valid = 0;
    last_w = exp_q.pop_front();
    mstat[2:0] = last_w[10:8];
    exp_q.push_back({4'h0, d});
  endtask

  task automatic set_mode(input logic m);
    fifo_mode = m;
    exp_q.delete();
    cap = m ? 16 : 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset values
    chk("R7 status", {8'd0, rx_status}, 12'h000);
    chk("R7 word", rd_word, 12'h000);
    chk("R7 empty", {11'd0, rx_empty}, 12'h001);
    chk("R7 full", {11'd0, rx_full}, 12'h000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 / R4: layout and status load on read
    send(8'hA5, 1, 0, 0);
    send(8'h3C, 0, 1, 0);
    send(8'h00, 0, 0, 1);
    chk("R4 no load on arrival", {8'd0, rx_status}, 12'h000);
    read("R1 ferr entry");
    send(8'h77, 1, 1, 1);
    chk("R4 hold after arrival", {8'd0, rx_status}, {8'd0, mstat});
    read("R1 perr entry");
    read("R1 brk entry");
    read("R4 all flags entry");
    chk_flags("R2 drained");

    // R2 fill, R5 overrun
    for (int i = 0; i < 16; i++) send(8'(8'h10 + i), 0, 0, 0);
    chk_flags("R2 full at depth");
    send(8'hEE, 0, 0, 0);
    chk("R5 overrun before read", {11'd0, rx_status[3]}, 12'h001);
    chk_flags("R5 still full");
    for (int i = 0; i < 16; i++) read("R2 R5 ordered drain");

    // R8 empty read
    read("R8 empty read");
    chk_flags("R8 flags");

    // R6 clear
    clr_err = 1; @(negedge clk); clr_err = 0; mstat = '0;
    chk("R6 cleared", {8'd0, rx_status}, 12'h000);

    // R10 read and arrival at full
    for (int i = 0; i < 16; i++) send(8'(8'h40 + i), 0, 1, 0);
    read_and_send(8'h99);
    chk("R10 no overrun", {8'd0, rx_status}, {8'd0, mstat});
    chk_flags("R10 still full");
    for (int i = 0; i < 16; i++) read("R10 drain");

    // R9 flush on mode change, R3 holding register
    send(8'h01, 0, 0, 0);
    send(8'h02, 0, 0, 0);
    set_mode(0);
    chk_flags("R9 flushed");
    send(8'h5A, 0, 1, 0);
    chk_flags("R3 full after one");
    send(8'h6B, 0, 0, 0);
    chk("R3 R5 overrun single", {11'd0, rx_status[3]}, 12'h001);
    read("R3 R5 holding word");
    chk_flags("R3 empty again");

    // R9 character in the switch cycle is dropped
    fifo_mode = 1; cap = 16;
    char_valid = 1; char_data = 8'hC3;
    @(negedge clk);
    char_valid = 0;
    chk_flags("R9 switch-cycle drop");
    read("R9 nothing stored");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule